// File: doc/BRIEF.md
# Load Replay Feedback Resolver

This block is the third pipeline stage of a load pipe. Each cycle it takes the outcome of the second stage: a valid flag, a cache-hit flag, the physical address and the replay causes (translation miss, data not yet available, miss queue full, store-forward failure, load-load ordering violation, uncached access). It also takes a kill from the redirect logic. The block picks a single feedback for the reservation station and registers it. The feedback says whether the load must be reissued and, if so, why.

In the registered stage, the block watches the cache refill bus. A load that was sent back only because the miss queue had no free entry is withdrawn from replay when a refill for the same cache block arrives in that cycle. The needed data is then already on its way. Replays caused by a translation miss or by data not yet available are never withdrawn. The stage also raises a writeback strobe for loads that complete here, together with a refetch flag for ordering and forwarding faults.

Top module: `ld_replay_resolver`

## Requirements
- R1: After reset, `fb_valid`, `fb_hit`, `wb_valid` and `refetch` are all low.
- R2: `fb_valid` is high in the cycle after a cycle with `s2_valid` high and `s2_kill` low, and low after any other cycle.
- R3: `fb_src` is a 2-bit code: 0 when a translation miss is present, otherwise 2 when data-not-ready is present, otherwise 1. Code 1 is also given when neither cause is present.
- R4: Causes are ranked as: translation miss, then forward failure or ordering violation, then uncached access, then data-not-ready, then miss queue full, then plain hit or miss. `fb_hit` is low (replay requested) only when the winning cause is a translation miss, data-not-ready or miss queue full.
- R5: A load that hits in the TLB and has a forward failure or an ordering violation is not replayed. It asserts `wb_valid` and `refetch` in stage 3.
- R6: An uncached load without a translation miss or fault is not replayed and raises no writeback here. This holds even when data-not-ready is also flagged.
- R7: A miss-queue-full replay reports `fb_hit` high in stage 3 when `refill_valid` is high in that same cycle and `refill_addr` matches the load address in bits [PA_W-1:OFF_W].
- R8: The block compare ignores the low OFF_W address bits. A refill that differs in any higher bit, or that arrives with `refill_valid` low, leaves the replay in place.
- R9: A replay whose winning cause is a translation miss or data-not-ready stays a replay, whatever the refill bus carries. This includes data-not-ready together with miss queue full.
- R10: `wb_valid` is high in stage 3 only for a non-replayed cache hit or a fault refetch. It is never high while `fb_valid` is high and `fb_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s2_valid | input | 1 | Stage-2 load present |
| s2_kill | input | 1 | Stage-2 load flushed by redirect |
| s2_hit | input | 1 | Stage-2 cache hit |
| s2_paddr | input | PA_W | Stage-2 physical address |
| s2_tlb_miss | input | 1 | Translation miss |
| s2_data_wait | input | 1 | Data not yet available |
| s2_mq_full | input | 1 | Miss queue could not accept the miss |
| s2_fwd_fail | input | 1 | Store-forward failure |
| s2_order_vio | input | 1 | Load-load ordering violation |
| s2_uncached | input | 1 | Uncached access |
| refill_valid | input | 1 | Refill bus valid |
| refill_addr | input | PA_W | Refill block address |
| fb_valid | output | 1 | Stage-3 feedback valid |
| fb_hit | output | 1 | 1 = no replay, 0 = reissue |
| fb_src | output | 2 | Replay source code (R3) |
| wb_valid | output | 1 | Stage-3 writeback strobe |
| refetch | output | 1 | Writeback needs refetch |

## Verification
Two events can meet in one cycle: a registered miss-queue-full replay leaves stage 3, and the refill bus returns data in that same cycle. The bench provokes this by issuing the load and then driving the refill in the cycle after. It uses matching blocks, addresses that differ only in low bits, addresses that differ in a high bit, and a refill whose valid is low. In each case it judges whether `fb_hit` flips. The same meeting is repeated with data-not-ready and with a translation miss present, and there the replay must survive.

// File: rtl/ld_fb_pkg.sv
package ld_fb_pkg;

  typedef enum logic [1:0] {
    SRC_TLB    = 2'd0,
    SRC_MQFULL = 2'd1,
    SRC_DWAIT  = 2'd2
  } fb_src_e;

  typedef struct packed {
    logic    hit;
    fb_src_e src;
    logic    mq_replay;
    logic    wb;
    logic    refetch;
  } verdict_t;

  // source code ranking among the three replay causes
  function automatic fb_src_e pick_src(input logic tlb, input logic dwait);
    if (tlb)        return SRC_TLB;
    else if (dwait) return SRC_DWAIT;
    else            return SRC_MQFULL;
  endfunction

endpackage

// File: rtl/ld_fb_classify.sv
module ld_fb_classify
  import ld_fb_pkg::*;
(
  input  logic     hit,
  input  logic     tlb_miss,
  input  logic     data_wait,
  input  logic     mq_full,
  input  logic     fwd_fail,
  input  logic     order_vio,
  input  logic     uncached,
  output verdict_t verdict
);
  logic fault;
  assign fault = fwd_fail | order_vio;

  always_comb begin
    verdict     = '0;
    verdict.src = pick_src(tlb_miss, data_wait);
    if (tlb_miss) begin
      verdict.hit = 1'b0;
    end else if (fault) begin
      verdict.hit     = 1'b1;
      verdict.wb      = 1'b1;
      verdict.refetch = 1'b1;
    end else if (uncached) begin
      verdict.hit = 1'b1;
    end else if (data_wait) begin
      verdict.hit = 1'b0;
    end else if (mq_full) begin
      verdict.hit       = 1'b0;
      verdict.mq_replay = 1'b1;
    end else begin
      verdict.hit = 1'b1;
      verdict.wb  = hit;
    end
  end
endmodule

// File: rtl/ld_fb_stage.sv
module ld_fb_stage
  import ld_fb_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  verdict_t        verdict_in,
  input  logic [PA_W-1:0] paddr_in,
  output logic            valid_q,
  output verdict_t        verdict_q,
  output logic [PA_W-1:0] paddr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
      paddr_q   <= '0;
    end else begin
      valid_q   <= take;
      verdict_q <= take ? verdict_in : '0;
      if (take) paddr_q <= paddr_in;
    end
  end
endmodule

// File: rtl/ld_block_match.sv
module ld_block_match #(
  parameter int PA_W  = 36,
  parameter int OFF_W = 6
) (
  input  logic [PA_W-1:0] addr_a,
  input  logic [PA_W-1:0] addr_b,
  output logic            same
);
  localparam int TAG_W = PA_W - OFF_W;
  logic [TAG_W-1:0] tag_a, tag_b;
  assign tag_a = addr_a[PA_W-1:OFF_W];
  assign tag_b = addr_b[PA_W-1:OFF_W];
  assign same  = (tag_a == tag_b);
endmodule

// File: rtl/ld_replay_resolver.sv
module ld_replay_resolver
  import ld_fb_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int OFF_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s2_valid,
  input  logic            s2_kill,
  input  logic            s2_hit,
  input  logic [PA_W-1:0] s2_paddr,
  input  logic            s2_tlb_miss,
  input  logic            s2_data_wait,
  input  logic            s2_mq_full,
  input  logic            s2_fwd_fail,
  input  logic            s2_order_vio,
  input  logic            s2_uncached,
  input  logic            refill_valid,
  input  logic [PA_W-1:0] refill_addr,
  output logic            fb_valid,
  output logic            fb_hit,
  output logic [1:0]      fb_src,
  output logic            wb_valid,
  output logic            refetch
);
  verdict_t        s2_verdict, s3_verdict;
  logic            s2_take, s3_valid, s3_block_eq, s3_mq_cancel;
  logic [PA_W-1:0] s3_paddr;

  assign s2_take = s2_valid & ~s2_kill;

  ld_fb_classify u_classify (
    .hit(s2_hit), .tlb_miss(s2_tlb_miss), .data_wait(s2_data_wait),
    .mq_full(s2_mq_full), .fwd_fail(s2_fwd_fail), .order_vio(s2_order_vio),
    .uncached(s2_uncached), .verdict(s2_verdict)
  );

  ld_fb_stage #(.PA_W(PA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .take(s2_take), .verdict_in(s2_verdict),
    .paddr_in(s2_paddr), .valid_q(s3_valid), .verdict_q(s3_verdict),
    .paddr_q(s3_paddr)
  );

  ld_block_match #(.PA_W(PA_W), .OFF_W(OFF_W)) u_match (
    .addr_a(s3_paddr), .addr_b(refill_addr), .same(s3_block_eq)
  );

  assign s3_mq_cancel = s3_valid & s3_verdict.mq_replay & refill_valid & s3_block_eq;

  assign fb_valid = s3_valid;
  assign fb_hit   = s3_valid & (s3_verdict.hit | s3_mq_cancel);
  assign fb_src   = s3_verdict.src;
  assign wb_valid = s3_valid & s3_verdict.wb;
  assign refetch  = s3_valid & s3_verdict.refetch;
endmodule

// File: rtl/ld_replay_resolver_chk.sv
module ld_replay_resolver_chk #(
  parameter int PA_W  = 36,
  parameter int OFF_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            s2_valid,
  input logic            s2_kill,
  input logic [PA_W-1:0] s2_paddr,
  input logic            s2_tlb_miss,
  input logic            s2_data_wait,
  input logic            s2_mq_full,
  input logic            s2_fwd_fail,
  input logic            s2_order_vio,
  input logic            s2_uncached,
  input logic            refill_valid,
  input logic [PA_W-1:0] refill_addr,
  input logic            fb_valid,
  input logic            fb_hit,
  input logic [1:0]      fb_src,
  input logic            wb_valid,
  input logic            s3_mq_cancel
);
  logic s2_take, mq_only, dwait_win;
  assign s2_take   = s2_valid & ~s2_kill;
  assign mq_only   = s2_mq_full & ~s2_tlb_miss & ~s2_data_wait & ~s2_fwd_fail
                     & ~s2_order_vio & ~s2_uncached;
  assign dwait_win = s2_data_wait & ~s2_tlb_miss & ~s2_fwd_fail & ~s2_order_vio
                     & ~s2_uncached;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_take |=> fb_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_take |=> !fb_valid);
  // R3
  tlb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_take && s2_tlb_miss) |=> (fb_src == 2'd0 && !fb_hit));
  // R9
  dwait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_take && dwait_win) |=> !fb_hit);
  // R7
  mq_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && refill_valid && $past(s2_take && mq_only)
     && refill_addr[PA_W-1:OFF_W] == $past(s2_paddr[PA_W-1:OFF_W])) |-> fb_hit);
  // R8
  no_refill_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !refill_valid |-> !s3_mq_cancel);
  // R10
  no_wb_on_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && !fb_hit) |-> !wb_valid);
endmodule

bind ld_replay_resolver ld_replay_resolver_chk #(.PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_kill(s2_kill),
  .s2_paddr(s2_paddr), .s2_tlb_miss(s2_tlb_miss), .s2_data_wait(s2_data_wait),
  .s2_mq_full(s2_mq_full), .s2_fwd_fail(s2_fwd_fail), .s2_order_vio(s2_order_vio),
  .s2_uncached(s2_uncached), .refill_valid(refill_valid), .refill_addr(refill_addr),
  .fb_valid(fb_valid), .fb_hit(fb_hit), .fb_src(fb_src), .wb_valid(wb_valid),
  .s3_mq_cancel(s3_mq_cancel)
);

// File: tb/ld_replay_resolver_test.sv
`timescale 1ns/1ps
module ld_replay_resolver_test;
  localparam int PA_W = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s2_valid = 0, s2_kill = 0, s2_hit = 0;
  logic [PA_W-1:0] s2_paddr = '0;
  logic s2_tlb_miss = 0, s2_data_wait = 0, s2_mq_full = 0;
  logic s2_fwd_fail = 0, s2_order_vio = 0, s2_uncached = 0;
  logic refill_valid = 0;
  logic [PA_W-1:0] refill_addr = '0;
  logic fb_valid, fb_hit, wb_valid, refetch;
  logic [1:0] fb_src;
  int checks = 0, errors = 0;
  logic done = 0;

  always #10 clk = ~clk;

  ld_replay_resolver uut (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_kill(s2_kill),
    .s2_hit(s2_hit), .s2_paddr(s2_paddr), .s2_tlb_miss(s2_tlb_miss),
    .s2_data_wait(s2_data_wait), .s2_mq_full(s2_mq_full),
    .s2_fwd_fail(s2_fwd_fail), .s2_order_vio(s2_order_vio),
    .s2_uncached(s2_uncached), .refill_valid(refill_valid),
    .refill_addr(refill_addr), .fb_valid(fb_valid), .fb_hit(fb_hit),
    .fb_src(fb_src), .wb_valid(wb_valid), .refetch(refetch)
  );

  // packed view: {valid, hit, src[1:0], wb, refetch}
  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {fb_valid, fb_hit, fb_src, wb_valid, refetch};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // flags: {hit, tlb, dwait, mq, fwd, vio, unc, kill}
  task automatic issue(input logic [7:0] f, input logic [PA_W-1:0] pa,
                       input logic rv, input logic [PA_W-1:0] ra);
    @(negedge clk);
    refill_valid = 0;
    s2_valid = 1;
    {s2_hit, s2_tlb_miss, s2_data_wait, s2_mq_full,
     s2_fwd_fail, s2_order_vio, s2_uncached, s2_kill} = f;
    s2_paddr = pa;
    @(negedge clk);
    s2_valid = 0;
    {s2_hit, s2_tlb_miss, s2_data_wait, s2_mq_full,
     s2_fwd_fail, s2_order_vio, s2_uncached, s2_kill} = '0;
    refill_valid = rv;
    refill_addr = ra;
    #2;
  endtask

  localparam logic [PA_W-1:0] A = 36'h8_1234_5680;

  task automatic t_reset();
    #2; chk("R1 reset", 6'b000000);
  endtask
  task automatic t_plain();
    issue(8'b1000_0000, A, 0, '0); chk("R10 plain hit writeback", 6'b110110);
    issue(8'b0000_0000, A, 0, '0); chk("R4 plain miss no replay", 6'b110100);
  endtask
  task automatic t_kill();
    issue(8'b1000_0001, A, 0, '0); chk("R2 killed load", 6'b000000);
  endtask
  task automatic t_priority();
    issue(8'b0111_0000, A, 1, A); chk("R3 tlb wins over all, R9 not withdrawn", 6'b100000);
    issue(8'b0011_0000, A, 1, A); chk("R9 dwait+mqfull kept despite refill", 6'b101000);
    issue(8'b0001_0000, A, 0, '0); chk("R3 mqfull replay code 1", 6'b100100);
  endtask
  task automatic t_fault();
    issue(8'b0000_1000, A, 0, '0); chk("R5 forward fail refetch", 6'b110111);
    issue(8'b0010_0100, A, 0, '0); chk("R5 ordering violation over dwait", 6'b111011);
    issue(8'b0100_1000, A, 0, '0); chk("R4 tlb miss over fault", 6'b100000);
  endtask
  task automatic t_uncached();
    issue(8'b0010_0010, A, 0, '0); chk("R6 uncached over dwait", 6'b111000);
  endtask
  task automatic t_mq_refill();
    issue(8'b0001_0000, A, 1, A); chk("R7 same block cancels", 6'b110100);
    issue(8'b0001_0000, A, 1, A ^ 36'h3F); chk("R8 low bits ignored", 6'b110100);
    issue(8'b0001_0000, A, 1, A ^ 36'h40); chk("R8 bit OFF_W differs", 6'b100100);
    issue(8'b0001_0000, A, 1, A ^ 36'h8_0000_0000); chk("R8 top bit differs", 6'b100100);
    issue(8'b0001_0000, A, 0, A); chk("R8 refill invalid", 6'b100100);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_plain();
    t_kill();
    t_priority();
    t_fault();
    t_uncached();
    t_mq_refill();
    @(negedge clk);
    refill_valid = 0;
    @(negedge clk);
    #2; chk("R2 idle after traffic", 6'b000000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule